// File: doc/BRIEF.md
# Trigger-term FIFO error monitor

This block watches a bank of single-bit trigger output terms. Each term has a mode. In FIFO mode it goes through a small decision queue. In test-data mode it is driven from a register bit. In bypass mode the input term passes straight through. For terms in FIFO mode the block detects four faults: a pop from an empty queue, a push into a full queue, a subsystem gap that was due but did not arrive, and a gap that arrived when none was due. Each fault is latched in a sticky status bit that software clears.

The block raises one interrupt request. Two sources feed it, queue-not-empty and fault, and each source has its own enable. A chip-wide enable gates both. A separate not-empty output, with its own enable, serves external sequencing logic. When a global hold line is high and the block is set to obey it, every output term is held low. Each term has a free-running counter of the pulses it drives, which software reads to work out rates. Clearing a channel's faults also empties its queue and holds the queue idle for a programmable number of cycles.

Registers sit behind a flat word-addressed interface. A write takes effect on the clock edge when `reg_we` is high. A read is combinational from `reg_addr`.

Top module: `tterm_fifo_mon`

## Requirements
- R1: Each channel has a 2-bit mode field at address 16+4*i, offset 0. Code 0 is FIFO, code 1 is test data, and codes 2 and 3 are bypass. It resets to 2. In bypass, `term_out[i]` follows `term_in[i]` one clock later. In test-data mode it follows bit i of the test register (address 2) one clock later.
- R2: In FIFO mode, `push` stores `term_in[i]` and `pop` removes the oldest entry. The queue holds 16 entries. The popped bit appears on `term_out[i]` for the one cycle after the pop. With no pop, a FIFO-mode output is 0.
- R3: The top NFIXED channels always read mode 2, ignore mode writes and always read zero status.
- R4: Status word (offset 1) bit 0 flags a pop while empty and bit 1 flags a push while full. A blocked pop or push leaves the pointers unchanged. The pointer word (offset 2) holds the read pointer in bits 3:0, the write pointer in bits 11:8, the in-reset flag in bit 16, full in bit 17 and empty in bit 18.
- R5: Status bit 2 flags `gap_due` without `gap_seen[i]`. Status bit 3 flags `gap_seen[i]` without `gap_due`.
- R6: A channel outside FIFO mode detects nothing. One cycle after it leaves FIFO mode, its status reads zero.
- R7: Fault bits are sticky. Writing a one to a status bit clears that bit only. A fault detected in the same cycle as the clear leaves the bit set.
- R8: A status write with any of bits 3:0 set empties that channel's queue. It also raises the in-reset flag for the number of cycles held at address 1. While the flag is high, push, pop and fault detection are ignored on that channel.
- R9: The control word is at address 0. `irq` = bit0 (chip enable) AND ((bit1 AND any FIFO-mode queue not empty) OR (bit2 AND any fault bit set)).
- R10: `fifo_ne` = control bit 4 AND any FIFO-mode queue not empty.
- R11: While `hold_in` is high and control bit 3 is set, all of `term_out` is 0. With bit 3 clear, `hold_in` has no effect.
- R12: The counter at offset 3 increments on every clock in which `term_out[i]` is high. It wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_in | input | NTERM | Incoming term values |
| push | input | 1 | Queue write strobe, shared by all channels |
| pop | input | 1 | Queue read strobe, shared by all channels |
| gap_due | input | 1 | A subsystem gap is expected this cycle |
| gap_seen | input | NTERM | Per-channel gap marker |
| hold_in | input | 1 | Global hold line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| term_out | output | NTERM | Output terms |
| fifo_ne | output | 1 | Some queue not empty |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pointer or flag shows up in two places: the popped term values on the next cycle, and the pointer word read back on the same cycle. The bench checks the popped values against a queue model. A lost or stray fault bit appears at once on `irq` and in the status word. A wrong in-reset countdown shows as a push that moves the write pointer too early, or a flag still high after the programmed length. Rate-counter drift shows as a wrong delta after a pulse train of known length.

// File: rtl/tterm_fifo_mon.sv
module tterm_fifo_mon #(
  parameter int NTERM  = 8,
  parameter int NFIXED = 2,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  parameter int RLEN_W = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTERM-1:0]  term_in,
  input  logic              push,
  input  logic              pop,
  input  logic              gap_due,
  input  logic [NTERM-1:0]  gap_seen,
  input  logic              hold_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NTERM-1:0]  term_out,
  output logic              fifo_ne,
  output logic              irq
);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CH_BASE = 16;

  logic chip_en, ne_irq_en, err_irq_en, hold_obey, ne_gen_en;
  logic [RLEN_W-1:0] rst_len;
  logic [NTERM-1:0]  tdr;
  logic hold_act;
  logic unused_bits;

  logic [NTERM-1:0][DATA_W-1:0] rd_v;
  logic [NTERM-1:0][3:0]        err_v;
  logic [NTERM-1:0][PTR_W-1:0]  wp_v, rp_v;
  logic [NTERM-1:0] ne_v, full_v, empty_v, fmode_v, clr_v, inrst_v;

  assign unused_bits = ^reg_wdata;
  assign hold_act    = hold_in & hold_obey;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_en    <= 1'b0;
      ne_irq_en  <= 1'b0;
      err_irq_en <= 1'b0;
      hold_obey  <= 1'b0;
      ne_gen_en  <= 1'b0;
      rst_len    <= '0;
      tdr        <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_W'(0): begin
          chip_en    <= reg_wdata[0];
          ne_irq_en  <= reg_wdata[1];
          err_irq_en <= reg_wdata[2];
          hold_obey  <= reg_wdata[3];
          ne_gen_en  <= reg_wdata[4];
        end
        ADDR_W'(1): rst_len <= reg_wdata[RLEN_W-1:0];
        ADDR_W'(2): tdr     <= reg_wdata[NTERM-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NTERM; i++) begin : g_ch
    localparam logic [ADDR_W-3:0] SLOT = (ADDR_W-2)'((CH_BASE + 4*i) / 4);
    localparam bit FIXED = (i >= NTERM - NFIXED);

    logic sel, fmode, inrst, live, clr, wr_ok, rd_ok, tq;
    logic [1:0] mode;
    logic [DEPTH-1:0] mem;
    logic [PTR_W-1:0] wp, rp, nwp, nrp;
    logic full, empty;
    logic [RLEN_W-1:0] rcnt;
    logic [3:0] err, new_err;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] word;

    assign sel = reg_addr[ADDR_W-1:2] == SLOT;

    if (FIXED) begin : g_fix
      assign mode = 2'd2;
    end else begin : g_mode
      always_ff @(posedge clk) begin
        if (!rst_n) mode <= 2'd2;
        else if (reg_we && sel && reg_addr[1:0] == 2'd0) mode <= reg_wdata[1:0];
      end
    end

    assign fmode   = mode == 2'd0;
    assign inrst   = rcnt != '0;
    assign live    = fmode & ~inrst;
    assign clr     = reg_we & sel & (reg_addr[1:0] == 2'd1) & (|reg_wdata[3:0]);
    assign wr_ok   = live & push & ~full;
    assign rd_ok   = live & pop & ~empty;
    assign nwp     = wp + {{(PTR_W-1){1'b0}}, wr_ok};
    assign nrp     = rp + {{(PTR_W-1){1'b0}}, rd_ok};
    assign new_err = live ? {gap_seen[i] & ~gap_due, gap_due & ~gap_seen[i],
                             push & full, pop & empty} : 4'b0;

    always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= term_in[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp    <= '0;
        rp    <= '0;
        full  <= 1'b0;
        empty <= 1'b1;
        rcnt  <= '0;
        err   <= '0;
        tq    <= 1'b0;
        cnt   <= '0;
      end else begin
        if (clr) begin
          wp    <= '0;
          rp    <= '0;
          full  <= 1'b0;
          empty <= 1'b1;
          rcnt  <= rst_len;
        end else begin
          rcnt <= rcnt - {{(RLEN_W-1){1'b0}}, inrst};
          wp   <= nwp;
          rp   <= nrp;
          if (wr_ok && !rd_ok) begin
            empty <= 1'b0;
            full  <= nwp == nrp;
          end else if (rd_ok && !wr_ok) begin
            full  <= 1'b0;
            empty <= nwp == nrp;
          end
        end
        err <= fmode ? ((err & ~(clr ? reg_wdata[3:0] : 4'b0)) | new_err) : 4'b0;
        case (mode)
          2'd0:    tq <= rd_ok & mem[rp];
          2'd1:    tq <= tdr[i];
          default: tq <= term_in[i];
        endcase
        if (term_out[i]) cnt <= cnt + CNT_W'(1);
      end
    end

    always_comb begin
      word = '0;
      case (reg_addr[1:0])
        2'd0: word[1:0] = mode;
        2'd1: word[3:0] = err;
        2'd2: begin
          word[PTR_W-1:0]  = rp;
          word[8 +: PTR_W] = wp;
          word[16]         = inrst;
          word[17]         = full;
          word[18]         = empty;
        end
        default: word[CNT_W-1:0] = cnt;
      endcase
    end

    assign rd_v[i]     = sel ? word : '0;
    assign term_out[i] = tq & ~hold_act;
    assign ne_v[i]     = fmode & ~empty;
    assign err_v[i]    = err;
    assign wp_v[i]     = wp;
    assign rp_v[i]     = rp;
    assign full_v[i]   = full;
    assign empty_v[i]  = empty;
    assign fmode_v[i]  = fmode;
    assign clr_v[i]    = clr;
    assign inrst_v[i]  = inrst;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(0): reg_rdata[4:0] = {ne_gen_en, hold_obey, err_irq_en, ne_irq_en, chip_en};
      ADDR_W'(1): reg_rdata[RLEN_W-1:0] = rst_len;
      ADDR_W'(2): reg_rdata[NTERM-1:0] = tdr;
      default: ;
    endcase
    for (int i = 0; i < NTERM; i++) reg_rdata = reg_rdata | rd_v[i];
  end

  assign fifo_ne = ne_gen_en & (|ne_v);
  assign irq     = chip_en & ((ne_irq_en & (|ne_v)) | (err_irq_en & (|err_v)));
endmodule

// File: rtl/tterm_fifo_mon_chk.sv
module tterm_fifo_mon_chk #(
  parameter int NTERM  = 8,
  parameter int NFIXED = 2,
  parameter int PTR_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hold_in,
  input logic                       hold_obey,
  input logic                       chip_en,
  input logic                       irq,
  input logic                       push,
  input logic                       pop,
  input logic [NTERM-1:0]           term_out,
  input logic [NTERM-1:0][3:0]      err_v,
  input logic [NTERM-1:0][PTR_W-1:0] wp_v,
  input logic [NTERM-1:0][PTR_W-1:0] rp_v,
  input logic [NTERM-1:0]           full_v,
  input logic [NTERM-1:0]           empty_v,
  input logic [NTERM-1:0]           fmode_v,
  input logic [NTERM-1:0]           clr_v,
  input logic [NTERM-1:0]           inrst_v
);
  a_r11_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_in && hold_obey) |-> term_out == '0);

  a_r9_irq_needs_chip: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> chip_en);

  for (genvar i = 0; i < NTERM; i++) begin : g_a
    a_r4_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_v[i] && empty_v[i]));

    a_r4_blocked_push: assert property (@(posedge clk) disable iff (!rst_n)
      (full_v[i] && push && !pop && !clr_v[i]) |=> $stable(wp_v[i]));

    a_r4_blocked_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_v[i] && pop && !push && !clr_v[i]) |=> $stable(rp_v[i]));

    a_r8_inrst_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (inrst_v[i] && !clr_v[i]) |=> ($stable(wp_v[i]) && $stable(rp_v[i])));

    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !fmode_v[i] |=> err_v[i] == 4'b0);

    for (genvar k = 0; k < 4; k++) begin : g_b
      a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_v[i][k] && fmode_v[i] && !clr_v[i]) |=> err_v[i][k]);
    end

    if (i >= NTERM - NFIXED) begin : g_f
      a_r3_fixed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        err_v[i] == 4'b0);
    end
  end
endmodule

bind tterm_fifo_mon tterm_fifo_mon_chk #(.NTERM(NTERM), .NFIXED(NFIXED), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .hold_obey(hold_obey),
  .chip_en(chip_en), .irq(irq), .push(push), .pop(pop), .term_out(term_out),
  .err_v(err_v), .wp_v(wp_v), .rp_v(rp_v), .full_v(full_v), .empty_v(empty_v),
  .fmode_v(fmode_v), .clr_v(clr_v), .inrst_v(inrst_v)
);

// File: tb/tterm_fifo_mon_test.sv
module tterm_fifo_mon_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0]  term_in, gap_seen;
  logic        push, pop, gap_due, hold_in, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  term_out;
  logic        fifo_ne, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_q[$];
  bit pop_expect = 0;
  bit mon_armed = 0;

  always #(CLK_P/2) clk = ~clk;

  tterm_fifo_mon uut (
    .clk(clk), .rst_n(rst_n), .term_in(term_in), .push(push), .pop(pop),
    .gap_due(gap_due), .gap_seen(gap_seen), .hold_in(hold_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .term_out(term_out), .fifo_ne(fifo_ne), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push_bit(input logic b);
    term_in[0] = b; push = 1'b1;
    exp_q.push_back(b);
    tick();
    push = 1'b0;
  endtask

  always @(posedge clk) mon_armed <= pop_expect;

  always @(negedge clk) begin
    if (mon_armed) begin
      logic e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'bx;
      chk("R2 popped term order", {31'b0, term_out[0]}, {31'b0, e});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    rst_n = 1'b0; term_in = '0; gap_seen = '0; push = 0; pop = 0; gap_due = 0;
    hold_in = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    chk("reset term_out", {24'b0, term_out}, 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R10 reset fifo_ne", {31'b0, fifo_ne}, 32'h0);
    rd(8'd0, v);  chk("reset ctrl", v, 32'h0);
    rd(8'd16, v); chk("R1 reset mode bypass", v, 32'h2);
    rd(8'd17, v); chk("reset status", v, 32'h0);

    // R1 bypass on ch1
    term_in = 8'h02;
    tick();
    chk("R1 bypass follows", {31'b0, term_out[1]}, 32'h1);

    // R11 hold
    wr(8'd0, 32'h08);
    hold_in = 1'b1; #1;
    chk("R11 hold forces low", {24'b0, term_out}, 32'h0);
    wr(8'd0, 32'h00);
    #1;
    chk("R11 hold ignored when not obeyed", {31'b0, term_out[1]}, 32'h1);
    hold_in = 1'b0;

    // R1 test-data on ch2
    wr(8'd24, 32'h1);
    wr(8'd2, 32'h04);
    tick();
    chk("R1 test data drives term", {31'b0, term_out[2]}, 32'h1);

    // R3 fixed channel, R6 bypass channel faults
    wr(8'd44, 32'h0);
    rd(8'd44, v); chk("R3 fixed mode stays bypass", v, 32'h2);
    gap_seen = 8'h82;
    tick();
    gap_seen = 8'h00;
    rd(8'd45, v); chk("R3 fixed status clear", v, 32'h0);
    rd(8'd21, v); chk("R6 bypass status clear", v, 32'h0);

    // R2 FIFO on ch0, R9 R10
    wr(8'd16, 32'h0);
    wr(8'd0, 32'h13);
    chk("R10 empty queue no ne", {31'b0, fifo_ne}, 32'h0);
    push_bit(1'b1); push_bit(1'b0); push_bit(1'b1); push_bit(1'b1);
    chk("R10 ne after push", {31'b0, fifo_ne}, 32'h1);
    chk("R9 ne irq", {31'b0, irq}, 32'h1);
    rd(8'd18, v); chk("R2 pointers after pushes", v, 32'h00000400);
    wr(8'd0, 32'h03);
    chk("R10 ne gen disabled", {31'b0, fifo_ne}, 32'h0);
    chk("R9 irq without ne gen", {31'b0, irq}, 32'h1);
    wr(8'd0, 32'h12);
    chk("R9 chip enable off", {31'b0, irq}, 32'h0);
    wr(8'd0, 32'h13);
    pop = 1'b1; pop_expect = 1'b1;
    repeat (4) tick();
    pop = 1'b0; pop_expect = 1'b0;
    tick(); tick();
    chk("R2 queue drained", {31'b0, fifo_ne}, 32'h0);
    chk("R9 irq drops when empty", {31'b0, irq}, 32'h0);

    // R4 underflow
    wr(8'd0, 32'h05);
    pop = 1'b1; tick(); pop = 1'b0;
    rd(8'd17, v); chk("R4 underflow bit", v, 32'h1);
    chk("R9 fault irq", {31'b0, irq}, 32'h1);
    rd(8'd18, v); chk("R4 blocked pop keeps pointers", v, 32'h00040404);

    // R8 clear and in-reset window
    wr(8'd1, 32'h3);
    wr(8'd17, 32'h1);
    rd(8'd17, v); chk("R8 status cleared", v, 32'h0);
    rd(8'd18, v); chk("R8 pointers reset in-reset high", v, 32'h00050000);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    term_in[0] = 1'b1; push = 1'b1; tick(); push = 1'b0;
    rd(8'd18, v); chk("R8 push ignored in reset", v, 32'h00050000);
    tick(); tick();
    rd(8'd18, v); chk("R8 in-reset ends", v, 32'h00040000);

    // R4 overflow
    term_in[0] = 1'b0; push = 1'b1;
    repeat (17) tick();
    push = 1'b0;
    rd(8'd17, v); chk("R4 overflow bit", v, 32'h2);
    rd(8'd18, v); chk("R4 full pointers", v, 32'h00020000);

    // R7 clear collides with new fault
    push = 1'b1;
    wr(8'd17, 32'h2);
    push = 1'b0;
    rd(8'd17, v); chk("R7 new fault wins clear", v, 32'h2);
    repeat (4) tick();

    // R5 gaps
    gap_due = 1'b1; tick(); gap_due = 1'b0;
    gap_seen = 8'h01; tick(); gap_seen = 8'h00;
    rd(8'd17, v); chk("R5 gap faults", v, 32'hE);
    wr(8'd17, 32'h4);
    rd(8'd17, v); chk("R7 partial clear", v, 32'hA);

    // R6 leaving FIFO mode
    wr(8'd16, 32'h2);
    tick();
    rd(8'd17, v); chk("R6 status clear off FIFO mode", v, 32'h0);

    // R12 rate counter on ch1
    term_in = 8'h00;
    repeat (3) tick();
    rd(8'd23, c0);
    term_in = 8'h02;
    repeat (5) tick();
    term_in = 8'h00;
    repeat (3) tick();
    rd(8'd23, v);
    chk("R12 rate counter delta", v - c0, 32'd5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule